// File: doc/BRIEF.md
# ADC Register-Mode Bus Sequencer

This block connects a host register interface to the parallel data bus of a converter that can leave its sample mode and expose internal registers over the same bus. The host loads a 16-bit write word and then writes a command code into an 8-bit control register. The sequencer then drives frames onto the bus, or samples a word from it, using write and read strobes that each stay high for a programmable number of cycles. A read result is kept in a read-back register.

A bus frame is 16 bits wide. The device register address sits in bits 15:8, with bit 15 acting as the read request flag. The data byte sits in bits 7:0. Besides the single-frame raw commands, the block runs two complete device-register sequences. Each one enters register mode, performs the access, and then writes an all-zero frame so the device goes back to sampling.

A command is taken from the write-data register as it stood before the control write. It starts only when the control register moves from zero to a recognised code while the block is idle. The strobe length is sampled from `settle_i` at that moment, and a value of zero is treated as one.

Top module: `adc_regbus_seq`

## Requirements
- R1: After reset, `busy_o`, `bus_wr_o`, `bus_rd_o` and `bus_drive_o` are 0 and `rd_word_o` is 0x0000.
- R2: Control code 0x01 drives the write word on `bus_dq_o` with `bus_wr_o` high for N cycles, where N is the sampled `settle_i` (0 counts as 1). The strobe rises on the clock edge that accepts the control write.
- R3: Control code 0x03 raises `bus_rd_o` for N cycles and stores the full 16-bit `bus_dq_i` value, sampled on the last strobe cycle, into `rd_word_o`.
- R4: `busy_o` rises on the same edge as the first strobe of a command and falls on the same edge as its last strobe. A command of S frames keeps `busy_o` high for S*N+S-1 cycles, because frames are separated by one cycle with no strobe.
- R5: A command starts only when the control register changes from 0x00 to 0x01, 0x03, 0x05 or 0x07. Rewriting a nonzero value, changing between nonzero values, or writing any other nonzero code produces no strobe and no busy.
- R6: A control write while `busy_o` is high is ignored and leaves the control register unchanged.
- R7: Control code 0x05 writes three frames: 0xAF00, then the write word with bit 15 forced to 0, then 0x0000.
- R8: Control code 0x07 writes the frame {1, word[14:8], 0x00}, then performs one bus read, then writes 0x0000. `rd_word_o` becomes {0x00, captured[7:0]}.
- R9: `rd_word_o` keeps its value until the next read command completes. Write commands never change it.
- R10: `bus_wr_o` and `bus_rd_o` are never high together, and `bus_drive_o` equals `bus_wr_o`.
- R11: Changes on `settle_i` while a command is running do not alter its strobe lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_we_i | input | 1 | Control register write enable |
| ctrl_wdata_i | input | 8 | Control register write value (command code) |
| wdata_we_i | input | 1 | Write-word register write enable |
| wdata_i | input | 16 | Write-word register value |
| settle_i | input | SET_W | Strobe length in cycles, sampled at command start |
| busy_o | output | 1 | Command in progress |
| rd_word_o | output | 16 | Read-back register |
| bus_dq_o | output | 16 | Frame driven toward the device |
| bus_drive_o | output | 1 | Output enable for `bus_dq_o` |
| bus_wr_o | output | 1 | Write strobe |
| bus_rd_o | output | 1 | Read strobe |
| bus_dq_i | input | 16 | Word returned by the device |

## Verification
Two things can land in the same cycle: a host control write, and the final strobe cycle that returns the sequencer to idle. The bench starts a long single-frame write and then writes 0x00 to the control register in exactly the last cycle in which `busy_o` is still high. That write has to be dropped, so a following 0x03 must find the register still nonzero and must start nothing. This is judged by confirming that neither strobe nor busy appears afterwards. Random commands with random settle lengths and random `settle_i` disturbance then compare every recorded strobe frame, kind and length, plus the busy duration and the read-back value, against bench-computed sequences.

// File: rtl/adc_regbus_pkg.sv
package adc_regbus_pkg;

    localparam int FRAME_W = 16;

    localparam logic [FRAME_W-1:0] FRAME_ENTER_REG = 16'hAF00;
    localparam logic [FRAME_W-1:0] FRAME_SAMPLE    = 16'h0000;

    typedef enum logic [7:0] {
        CMD_NONE   = 8'h00,
        CMD_RAW_WR = 8'h01,
        CMD_RAW_RD = 8'h03,
        CMD_DEV_WR = 8'h05,
        CMD_DEV_RD = 8'h07
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STROBE,
        ST_GAP
    } state_e;

endpackage

// File: rtl/adc_regbus_plan.sv
module adc_regbus_plan
    import adc_regbus_pkg::*;
(
    input  logic [7:0]         cmd_i,
    input  logic [FRAME_W-1:0] word_i,
    input  logic [1:0]         step_i,
    output logic [FRAME_W-1:0] frame_o,
    output logic               read_o,
    output logic               last_o,
    output logic               known_o
);

    always_comb begin
        frame_o = FRAME_SAMPLE;
        read_o  = 1'b0;
        last_o  = 1'b1;
        known_o = 1'b1;
        case (cmd_i)
            CMD_RAW_WR: frame_o = word_i;
            CMD_RAW_RD: read_o  = 1'b1;
            CMD_DEV_WR: begin
                case (step_i)
                    2'd0: begin
                        frame_o = FRAME_ENTER_REG;
                        last_o  = 1'b0;
                    end
                    2'd1: begin
                        frame_o = {1'b0, word_i[FRAME_W-2:0]};
                        last_o  = 1'b0;
                    end
                    default: frame_o = FRAME_SAMPLE;
                endcase
            end
            CMD_DEV_RD: begin
                case (step_i)
                    2'd0: begin
                        frame_o = {1'b1, word_i[FRAME_W-2:8], 8'h00};
                        last_o  = 1'b0;
                    end
                    2'd1: begin
                        read_o  = 1'b1;
                        last_o  = 1'b0;
                    end
                    default: frame_o = FRAME_SAMPLE;
                endcase
            end
            default: known_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/adc_regbus_strobe.sv
module adc_regbus_strobe #(
    parameter int CNT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             launch_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             active_o,
    output logic             last_o
);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
    } stb_t;

    stb_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (launch_i) begin
            s_d.active = 1'b1;
            s_d.cnt    = len_i - CNT_W'(1);
        end else if (s_q.active) begin
            if (s_q.cnt == '0) begin
                s_d.active = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign active_o = s_q.active;
    assign last_o   = s_q.active && (s_q.cnt == '0);

    // R2: a strobe with cycles left stays high
    a_r2_strobe_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.active && s_q.cnt != '0) |=> active_o);

    // R4: a new strobe is never launched over a running one
    a_r4_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        launch_i |-> !s_q.active);

    // R2: a launch shows up as an active strobe on the next cycle
    a_r2_launch_seen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        launch_i |=> active_o);

endmodule

// File: rtl/adc_regbus_seq.sv
module adc_regbus_seq
    import adc_regbus_pkg::*;
#(
    parameter int SET_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ctrl_we_i,
    input  logic [7:0]       ctrl_wdata_i,
    input  logic             wdata_we_i,
    input  logic [15:0]      wdata_i,
    input  logic [SET_W-1:0] settle_i,
    output logic             busy_o,
    output logic [15:0]      rd_word_o,
    output logic [15:0]      bus_dq_o,
    output logic             bus_drive_o,
    output logic             bus_wr_o,
    output logic             bus_rd_o,
    input  logic [15:0]      bus_dq_i
);

    localparam logic [SET_W-1:0] MIN_LEN = SET_W'(1);

    typedef struct packed {
        state_e             state;
        logic [7:0]         ctrl;
        logic [7:0]         cmd;
        logic [FRAME_W-1:0] wdata;
        logic [FRAME_W-1:0] word;
        logic [SET_W-1:0]   settle;
        logic [1:0]         step;
        logic [FRAME_W-1:0] frame;
        logic               rd_step;
        logic               last_step;
        logic [FRAME_W-1:0] rdback;
    } regs_t;

    regs_t r_d, r_q;

    logic               busy;
    logic               host_ok;
    logic               go;
    logic [SET_W-1:0]   settle_eff;
    logic [7:0]         p_cmd;
    logic [FRAME_W-1:0] p_word;
    logic [1:0]         p_step;
    logic [FRAME_W-1:0] p_frame;
    logic               p_read;
    logic               p_last;
    logic               p_known;
    logic               launch;
    logic [SET_W-1:0]   launch_len;
    logic               stb_active;
    logic               stb_last;
    logic               capture;

    adc_regbus_plan u_plan (
        .cmd_i   (p_cmd),
        .word_i  (p_word),
        .step_i  (p_step),
        .frame_o (p_frame),
        .read_o  (p_read),
        .last_o  (p_last),
        .known_o (p_known)
    );

    adc_regbus_strobe #(
        .CNT_W (SET_W)
    ) u_strobe (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .launch_i (launch),
        .len_i    (launch_len),
        .active_o (stb_active),
        .last_o   (stb_last)
    );

    always_comb begin
        busy       = (r_q.state != ST_IDLE);
        host_ok    = ctrl_we_i && !busy;
        settle_eff = (settle_i == '0) ? MIN_LEN : settle_i;

        // the plan looks at the incoming code when idle, else the next step
        if (r_q.state == ST_IDLE) begin
            p_cmd  = ctrl_wdata_i;
            p_word = r_q.wdata;
            p_step = 2'd0;
        end else begin
            p_cmd  = r_q.cmd;
            p_word = r_q.word;
            p_step = r_q.step + 2'd1;
        end

        go = host_ok && (r_q.ctrl == 8'h00) && (ctrl_wdata_i != 8'h00) && p_known;
        capture = (r_q.state == ST_STROBE) && stb_last && r_q.rd_step;

        r_d        = r_q;
        launch     = 1'b0;
        launch_len = r_q.settle;

        if (wdata_we_i) begin
            r_d.wdata = wdata_i;
        end
        if (host_ok) begin
            r_d.ctrl = ctrl_wdata_i;
        end

        case (r_q.state)
            ST_IDLE: begin
                if (go) begin
                    r_d.cmd       = ctrl_wdata_i;
                    r_d.word      = r_q.wdata;
                    r_d.settle    = settle_eff;
                    r_d.step      = 2'd0;
                    r_d.frame     = p_frame;
                    r_d.rd_step   = p_read;
                    r_d.last_step = p_last;
                    r_d.state     = ST_STROBE;
                    launch        = 1'b1;
                    launch_len    = settle_eff;
                end
            end
            ST_STROBE: begin
                if (stb_last) begin
                    if (r_q.rd_step) begin
                        r_d.rdback = (r_q.cmd == CMD_RAW_RD) ? bus_dq_i
                                                             : {8'h00, bus_dq_i[7:0]};
                    end
                    r_d.state = r_q.last_step ? ST_IDLE : ST_GAP;
                end
            end
            ST_GAP: begin
                r_d.step      = p_step;
                r_d.frame     = p_frame;
                r_d.rd_step   = p_read;
                r_d.last_step = p_last;
                r_d.state     = ST_STROBE;
                launch        = 1'b1;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o      = busy;
    assign rd_word_o   = r_q.rdback;
    assign bus_dq_o    = r_q.frame;
    assign bus_wr_o    = stb_active && !r_q.rd_step;
    assign bus_rd_o    = stb_active && r_q.rd_step;
    assign bus_drive_o = bus_wr_o;

    // R10: only one strobe at a time
    a_r10_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(bus_wr_o && bus_rd_o));

    // R4: any strobe lies inside a busy window
    a_r4_strobe_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_o || bus_rd_o) |-> busy_o);

    // R4: busy ends on the edge that drops the final strobe
    a_r4_busy_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> ($fell(bus_wr_o) || $fell(bus_rd_o)));

    // R6: control writes during busy leave the control register alone
    a_r6_busy_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && ctrl_we_i) |=> $stable(r_q.ctrl));

    // R5: with a nonzero control value an idle write cannot start anything
    a_r5_no_rearm: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && ctrl_we_i && r_q.ctrl != 8'h00) |=> !busy_o);

    // R9: read-back changes only when a read strobe completes
    a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !capture |=> $stable(rd_word_o));

endmodule

// File: tb/adc_regbus_seq_bench.sv
module adc_regbus_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int SW = 4;

    logic          clk;
    logic          rst_n;
    logic          ctrl_we;
    logic [7:0]    ctrl_wdata;
    logic          wdata_we;
    logic [15:0]   wdata;
    logic [SW-1:0] settle;
    logic          busy;
    logic [15:0]   rd_word;
    logic [15:0]   bus_dq_o;
    logic          bus_drive;
    logic          bus_wr;
    logic          bus_rd;
    logic [15:0]   bus_dq_i;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    adc_regbus_seq #(.SET_W(SW)) u_adc_regbus_seq (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .ctrl_we_i    (ctrl_we),
        .ctrl_wdata_i (ctrl_wdata),
        .wdata_we_i   (wdata_we),
        .wdata_i      (wdata),
        .settle_i     (settle),
        .busy_o       (busy),
        .rd_word_o    (rd_word),
        .bus_dq_o     (bus_dq_o),
        .bus_drive_o  (bus_drive),
        .bus_wr_o     (bus_wr),
        .bus_rd_o     (bus_rd),
        .bus_dq_i     (bus_dq_i)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // strobe monitor: records each strobe pulse as one event
    int          ev_n = 0;
    logic        ev_kind  [0:7];
    logic [15:0] ev_frame [0:7];
    int          ev_len   [0:7];
    int          run = 0;
    logic        cur_kind;
    logic [15:0] cur_frame;
    int          busy_cnt = 0;
    int          r10_bad = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if ((bus_wr && bus_rd) || (bus_drive != bus_wr)) r10_bad++;
            if (busy) busy_cnt++;
            if (bus_wr || bus_rd) begin
                if (run == 0) begin
                    cur_kind  = bus_rd;
                    cur_frame = bus_dq_o;
                end
                run++;
            end else if (run != 0) begin
                if (ev_n < 8) begin
                    ev_kind[ev_n]  = cur_kind;
                    ev_frame[ev_n] = cur_frame;
                    ev_len[ev_n]   = run;
                end
                ev_n++;
                run = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_n(input logic [7:0] c);
        case (c)
            8'h01, 8'h03: return 1;
            8'h05, 8'h07: return 3;
            default:      return 0;
        endcase
    endfunction

    function automatic logic [16:0] exp_ev(input logic [7:0] c, input logic [15:0] w, input int i);
        case (c)
            8'h01: return {1'b0, w};
            8'h03: return {1'b1, 16'h0000};
            8'h05: begin
                if (i == 0) return {1'b0, 16'hAF00};
                if (i == 1) return {1'b0, 1'b0, w[14:0]};
                return 17'h0;
            end
            8'h07: begin
                if (i == 0) return {1'b0, 1'b1, w[14:8], 8'h00};
                if (i == 1) return {1'b1, 16'h0000};
                return 17'h0;
            end
            default: return 17'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] c);
        case (c)
            8'h01:   return "R2";
            8'h03:   return "R3";
            8'h05:   return "R7";
            default: return "R8";
        endcase
    endfunction

    logic [15:0] exp_rd = 16'h0000;

    task automatic wait_idle();
        for (int k = 0; k < 300 && busy; k++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic host_ctrl(input logic [7:0] c);
        @(negedge clk);
        ctrl_we    = 1'b1;
        ctrl_wdata = c;
        @(negedge clk);
        ctrl_we    = 1'b0;
    endtask

    task automatic run_cmd(input logic [7:0] c, input logic [15:0] w,
                           input logic [SW-1:0] s, input logic [15:0] resp, input bit wiggle);
        int n;
        int len;
        logic [16:0] e;
        @(negedge clk);
        wdata_we   = 1'b1;
        wdata      = w;
        ctrl_we    = 1'b1;
        ctrl_wdata = 8'h00;
        settle     = s;
        bus_dq_i   = resp;
        @(negedge clk);
        wdata_we   = 1'b0;
        ctrl_wdata = c;
        ev_n       = 0;
        busy_cnt   = 0;
        @(negedge clk);
        ctrl_we = 1'b0;
        chk(busy == 1'b1, "R4 busy rise", busy, 1);
        if (wiggle) begin
            while (busy) begin
                settle = SW'($urandom);
                @(negedge clk);
            end
        end
        wait_idle();
        n   = exp_n(c);
        len = (s == 0) ? 1 : int'(s);
        chk(ev_n == n, tag_of(c), ev_n, n);
        for (int i = 0; i < n && i < ev_n; i++) begin
            e = exp_ev(c, w, i);
            chk(ev_kind[i] == e[16], tag_of(c), ev_kind[i], e[16]);
            if (!e[16]) chk(ev_frame[i] == e[15:0], tag_of(c), ev_frame[i], e[15:0]);
            chk(ev_len[i] == len, wiggle ? "R11" : "R2", ev_len[i], len);
        end
        chk(busy_cnt == n * len + n - 1, "R4 busy length", busy_cnt, n * len + n - 1);
        if (c == 8'h03) exp_rd = resp;
        if (c == 8'h07) exp_rd = {8'h00, resp[7:0]};
        chk(rd_word == exp_rd, (c == 8'h03 || c == 8'h07) ? tag_of(c) : "R9",
            rd_word, exp_rd);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n      = 1'b0;
        ctrl_we    = 1'b0;
        ctrl_wdata = 8'h00;
        wdata_we   = 1'b0;
        wdata      = 16'h0;
        settle     = '0;
        bus_dq_i   = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(busy == 0 && bus_wr == 0 && bus_rd == 0 && bus_drive == 0, "R1", busy, 0);
        chk(rd_word == 16'h0, "R1", rd_word, 0);

        // R2 with settle 0 treated as one cycle
        run_cmd(8'h01, 16'h1234, 4'd0, 16'h0, 1'b0);
        // R3 with settle changing mid-command (R11)
        run_cmd(8'h03, 16'h0000, 4'd5, 16'hBEEF, 1'b1);
        // R7 and R8 directed, R9 after a device write
        run_cmd(8'h07, 16'hFF42, 4'd3, 16'h5A6C, 1'b0);
        run_cmd(8'h05, 16'h8311, 4'd2, 16'h7777, 1'b0);

        // R5: rewrite nonzero, switch nonzero, unknown code
        ev_n = 0;
        busy_cnt = 0;
        host_ctrl(8'h05);
        host_ctrl(8'h03);
        host_ctrl(8'h00);
        host_ctrl(8'h02);
        repeat (20) @(negedge clk);
        chk(ev_n == 0, "R5 no strobe", ev_n, 0);
        chk(busy_cnt == 0, "R5 no busy", busy_cnt, 0);

        // R6: clear written in the final busy cycle must be dropped
        host_ctrl(8'h00);
        @(negedge clk);
        settle     = 4'd8;
        ctrl_we    = 1'b1;
        ctrl_wdata = 8'h01;
        @(negedge clk);
        ctrl_we = 1'b0;
        repeat (7) @(negedge clk);
        chk(busy == 1'b1, "R6 last busy cycle", busy, 1);
        ctrl_we    = 1'b1;
        ctrl_wdata = 8'h00;
        @(negedge clk);
        ctrl_we = 1'b0;
        wait_idle();
        ev_n = 0;
        busy_cnt = 0;
        host_ctrl(8'h03);
        repeat (20) @(negedge clk);
        chk(ev_n == 0, "R6 clear ignored", ev_n, 0);
        chk(busy_cnt == 0, "R6 no busy", busy_cnt, 0);
        chk(rd_word == exp_rd, "R9", rd_word, exp_rd);

        // random mix
        for (int t = 0; t < 40; t++) begin
            logic [7:0] c;
            c = 8'(($urandom % 4) * 2 + 1);
            run_cmd(c, 16'($urandom), SW'($urandom % 7), 16'($urandom), 1'($urandom));
        end

        chk(r10_bad == 0, "R10", r10_bad, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule